// File: doc/BRIEF.md
# Registered Cascadable Magnitude Comparator

This block compares two words, P and Q, and reports exactly one of three decisions: P is above Q, P is below Q, or the two are equal. A single mode input chooses whether the words are treated as plain unsigned magnitudes or as two's complement numbers.

P and Q each sit in their own storage register, and each register has a separate active-high load enable. A third register, with its own load enable, holds the three result bits. Each register captures its input on a clock edge while its enable is high. While the enable is low, the register keeps its value. An active-low clear empties the Q register at once, whatever its load enable is doing, so the stored P can be tested against zero without driving a zero word onto the Q inputs.

For words wider than one stage, stages can be chained. The above and below outputs of a lower-order stage drive the two cascade inputs of the next higher stage. Only the top stage of a chain uses two's complement mode. The equality outputs of all stages can be ANDed outside the block.

Top module: `mag_cmp_stage`

## Requirements
- R1: While rst_n is low, the stored P word, the stored Q word and all three result outputs are zero.
- R2: On a rising clock edge with p_load high, the P register takes p_in. With p_load low it keeps its value, and changes on p_in do not reach the result.
- R3: On a rising clock edge with q_load high and q_clr_n high, the Q register takes q_in. With q_load low it keeps its value, and changes on q_in do not reach the result.
- R4: q_clr_n low clears the Q register to zero at once, without waiting for a clock edge, and overrides q_load. After q_clr_n returns high, Q stays zero until the next load.
- R5: With logic_mode = 1, the stored words are compared as unsigned numbers.
- R6: With logic_mode = 0, the stored words are compared as two's complement numbers. A P word with its top bit set is always below a Q word with its top bit clear.
- R7: When the stored words differ, gt_out and lt_out come from the local comparison alone, eq_out is low, and gt_in and lt_in have no effect.
- R8: When the stored words are equal, gt_out follows gt_in and lt_out follows lt_in. eq_out is high only if both cascade inputs are low.
- R9: Whenever eq_out is high, gt_out and lt_out are both low.
- R10: The result outputs take the comparison of the currently stored words on a rising clock edge with res_load high, so they appear one edge after the words are stored. With res_load low, the outputs stay unchanged.
- R11: With each stage's gt_out and lt_out wired to gt_in and lt_in of the next higher stage, and the lowest stage's cascade inputs tied low, the top stage of a 2-stage or 3-stage chain gives the correct 16-bit or 24-bit comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p_in | input | W | P operand |
| q_in | input | W | Q operand |
| p_load | input | 1 | P register load enable |
| q_load | input | 1 | Q register load enable |
| res_load | input | 1 | Result register load enable |
| q_clr_n | input | 1 | Asynchronous clear of the Q register, active low |
| logic_mode | input | 1 | 1 = unsigned compare, 0 = two's complement compare |
| gt_in | input | 1 | Above result from the lower-order stage |
| lt_in | input | 1 | Below result from the lower-order stage |
| gt_out | output | 1 | P above Q |
| lt_out | output | 1 | P below Q |
| eq_out | output | 1 | P equals Q, with no decision coming up the cascade |

## Verification
The assertions check on every clock edge that each register loads or holds according to its enable, that the clear forces Q to zero, and that eq_out never appears together with either direction. They also check that differing words block the cascade, that equal words pass the cascade through, and that a negative P sorts below a non-negative Q in two's complement mode. Only the bench scenarios can show that full magnitude ordering is correct across many operand pairs, that the clear acts without a clock edge, and that 16-bit and 24-bit chains agree with a wide reference comparison.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_res_t;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/mcmp_hold_reg.sv
module mcmp_hold_reg #(
    parameter int W       = 8,
    parameter int HAS_CLR = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam logic CLR_EN = (HAS_CLR != 0);

    logic [W-1:0] val_d;
    logic [W-1:0] val_q;
    logic         arst_n;

    // the clear joins the async reset only in the variant that has one
    assign arst_n = rst_n & (clr_n | ~CLR_EN);

    always_comb begin
        val_d = val_q;
        if (load) begin
            val_d = din;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign dout = val_q;

endmodule

// File: rtl/mcmp_core.sv
module mcmp_core
    import mcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] p_val,
    input  logic [W-1:0] q_val,
    input  logic         logic_mode,
    input  logic         gt_in,
    input  logic         lt_in,
    output cmp_res_t     res
);

    localparam int MSB = W - 1;

    logic [W-1:0] p_ord;
    logic [W-1:0] q_ord;
    logic         sign_flip;
    logic         words_differ;
    logic         local_gt;

    // two's complement order equals unsigned order with the sign bit inverted
    assign sign_flip = (cmp_mode_e'(logic_mode) == MODE_ARITH);
    assign p_ord     = {p_val[MSB] ^ sign_flip, p_val[MSB-1:0]};
    assign q_ord     = {q_val[MSB] ^ sign_flip, q_val[MSB-1:0]};

    assign words_differ = (p_ord != q_ord);
    assign local_gt     = (p_ord > q_ord);

    always_comb begin
        res = '0;
        if (words_differ) begin
            res.gt = local_gt;
            res.lt = ~local_gt;
            res.eq = 1'b0;
        end else begin
            res.gt = gt_in;
            res.lt = lt_in;
            res.eq = ~(gt_in | lt_in);
        end
    end

endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
    import mcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] p_in,
    input  logic [W-1:0] q_in,
    input  logic         p_load,
    input  logic         q_load,
    input  logic         res_load,
    input  logic         q_clr_n,
    input  logic         logic_mode,
    input  logic         gt_in,
    input  logic         lt_in,
    output logic         gt_out,
    output logic         lt_out,
    output logic         eq_out
);

    localparam int RES_W = $bits(cmp_res_t);

    logic [W-1:0]     p_q;
    logic [W-1:0]     q_q;
    cmp_res_t         res_d;
    logic [RES_W-1:0] res_q;
    cmp_res_t         res_s;

    mcmp_hold_reg #(.W(W), .HAS_CLR(0)) p_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (1'b1),
        .load  (p_load),
        .din   (p_in),
        .dout  (p_q)
    );

    mcmp_hold_reg #(.W(W), .HAS_CLR(1)) q_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (q_clr_n),
        .load  (q_load),
        .din   (q_in),
        .dout  (q_q)
    );

    mcmp_core #(.W(W)) core_i (
        .p_val      (p_q),
        .q_val      (q_q),
        .logic_mode (logic_mode),
        .gt_in      (gt_in),
        .lt_in      (lt_in),
        .res        (res_d)
    );

    mcmp_hold_reg #(.W(RES_W), .HAS_CLR(0)) res_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (1'b1),
        .load  (res_load),
        .din   (res_d),
        .dout  (res_q)
    );

    assign res_s  = cmp_res_t'(res_q);
    assign gt_out = res_s.gt;
    assign lt_out = res_s.lt;
    assign eq_out = res_s.eq;

endmodule

// File: rtl/mag_cmp_stage_chk.sv
module mag_cmp_stage_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] p_in,
    input logic [W-1:0] q_in,
    input logic         p_load,
    input logic         q_load,
    input logic         res_load,
    input logic         q_clr_n,
    input logic         logic_mode,
    input logic         gt_in,
    input logic         lt_in,
    input logic [W-1:0] p_q,
    input logic [W-1:0] q_q,
    input logic         gt_out,
    input logic         lt_out,
    input logic         eq_out
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (p_q == '0 && q_q == '0 && !gt_out && !lt_out && !eq_out)); // R1

    AST_P_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        p_load |=> (p_q == $past(p_in))); // R2

    AST_P_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !p_load |=> $stable(p_q)); // R2

    AST_Q_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_load && q_clr_n) |=> (q_q == $past(q_in) || q_q == '0)); // R3

    AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_load && q_clr_n) |=> (q_q == $past(q_q) || q_q == '0)); // R3

    AST_Q_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !q_clr_n |-> (q_q == '0)); // R4

    AST_ARITH_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && !logic_mode && p_q[W-1] && !q_q[W-1]) |=> (lt_out && !gt_out)); // R6

    AST_DIFF_BLOCKS_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && p_q != q_q) |=> (!eq_out && (gt_out != lt_out))); // R7

    AST_EQUAL_PASSES_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && p_q == q_q) |=> (gt_out == $past(gt_in) && lt_out == $past(lt_in))); // R8

    AST_EQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        eq_out |-> (!gt_out && !lt_out)); // R9

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_load |=> $stable({gt_out, lt_out, eq_out})); // R10

endmodule

bind mag_cmp_stage mag_cmp_stage_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .p_in       (p_in),
    .q_in       (q_in),
    .p_load     (p_load),
    .q_load     (q_load),
    .res_load   (res_load),
    .q_clr_n    (q_clr_n),
    .logic_mode (logic_mode),
    .gt_in      (gt_in),
    .lt_in      (lt_in),
    .p_q        (p_q),
    .q_q        (q_q),
    .gt_out     (gt_out),
    .lt_out     (lt_out),
    .eq_out     (eq_out)
);

// File: tb/mag_cmp_stage_tb_top.sv
module mag_cmp_stage_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic       rst_n;
    logic [7:0] p_in, q_in;
    logic       p_load, q_load, res_load, q_clr_n, logic_mode, gt_in, lt_in;
    logic       gt_out, lt_out, eq_out;

    mag_cmp_stage #(.W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .p_in(p_in), .q_in(q_in),
        .p_load(p_load), .q_load(q_load), .res_load(res_load),
        .q_clr_n(q_clr_n), .logic_mode(logic_mode),
        .gt_in(gt_in), .lt_in(lt_in),
        .gt_out(gt_out), .lt_out(lt_out), .eq_out(eq_out)
    );

    // chains for R11
    logic [23:0] c_p, c_q;
    logic        c_mode;
    logic [2:0]  c2_gt, c2_lt, c2_eq;
    logic [3:0]  c3_gt, c3_lt, c3_eq;

    assign c2_gt[0] = 1'b0;
    assign c2_lt[0] = 1'b0;
    assign c3_gt[0] = 1'b0;
    assign c3_lt[0] = 1'b0;
    assign c2_eq[0] = 1'b1;
    assign c3_eq[0] = 1'b1;

    for (genvar k = 0; k < 2; k++) begin : g_c2
        mag_cmp_stage #(.W(8)) st_i (
            .clk(clk), .rst_n(rst_n), .p_in(c_p[8*k +: 8]), .q_in(c_q[8*k +: 8]),
            .p_load(1'b1), .q_load(1'b1), .res_load(1'b1), .q_clr_n(1'b1),
            .logic_mode((k == 1) ? c_mode : 1'b1),
            .gt_in(c2_gt[k]), .lt_in(c2_lt[k]),
            .gt_out(c2_gt[k+1]), .lt_out(c2_lt[k+1]), .eq_out(c2_eq[k+1])
        );
    end

    for (genvar k = 0; k < 3; k++) begin : g_c3
        mag_cmp_stage #(.W(8)) st_i (
            .clk(clk), .rst_n(rst_n), .p_in(c_p[8*k +: 8]), .q_in(c_q[8*k +: 8]),
            .p_load(1'b1), .q_load(1'b1), .res_load(1'b1), .q_clr_n(1'b1),
            .logic_mode((k == 2) ? c_mode : 1'b1),
            .gt_in(c3_gt[k]), .lt_in(c3_lt[k]),
            .gt_out(c3_gt[k+1]), .lt_out(c3_lt[k+1]), .eq_out(c3_eq[k+1])
        );
    end

    // expected {gt,lt,eq} from the requirements
    function automatic logic [2:0] ref_cmp(input logic [23:0] p, input logic [23:0] q,
                                           input int width, input bit mode,
                                           input bit gi, input bit li);
        longint pv, qv, span;
        span = longint'(1) << width;
        pv = longint'(p) & (span - 1);
        qv = longint'(q) & (span - 1);
        if (!mode) begin
            if (pv >= span / 2) pv -= span;
            if (qv >= span / 2) qv -= span;
        end
        if (pv > qv) return 3'b100;
        if (pv < qv) return 3'b010;
        return {gi, li, ~(gi | li)};
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {gt_out, lt_out, eq_out};
    endfunction

    // drive at a falling edge; result reaches the outputs after two rising edges
    task automatic apply(input logic [7:0] p, input logic [7:0] q, input bit mode,
                         input bit gi, input bit li);
        p_in = p; q_in = q; logic_mode = mode; gt_in = gi; lt_in = li;
        p_load = 1'b1; q_load = 1'b1; res_load = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        p_in = 8'h5A; q_in = 8'h33; p_load = 1'b1; q_load = 1'b1; res_load = 1'b1;
        q_clr_n = 1'b1; logic_mode = 1'b1; gt_in = 1'b1; lt_in = 1'b0;
        c_p = '0; c_q = '0; c_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", outs(), 3'b000);
        rst_n = 1'b1;
    endtask

    task automatic t_unsigned();
        apply(8'd200, 8'd100, 1'b1, 1'b0, 1'b0); check("R5 200>100", outs(), 3'b100);
        apply(8'h7F, 8'h80, 1'b1, 1'b0, 1'b0);   check("R5 7F<80", outs(), 3'b010);
        apply(8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);   check("R5 FF>00", outs(), 3'b100);
        apply(8'h3C, 8'h3C, 1'b1, 1'b0, 1'b0);   check("R5 equal", outs(), 3'b001);
        for (int i = 0; i < 20; i++) begin
            logic [7:0] a, b;
            a = 8'((i * 37 + 11) % 256);
            b = 8'((i * 91 + 200) % 256);
            apply(a, b, 1'b1, 1'b0, 1'b0);
            check("R5 sweep", outs(), ref_cmp({16'h0, a}, {16'h0, b}, 8, 1'b1, 1'b0, 1'b0));
        end
    endtask

    task automatic t_signed();
        apply(8'h80, 8'h7F, 1'b0, 1'b0, 1'b0); check("R6 -128<127", outs(), 3'b010);
        apply(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0); check("R6 -1<1", outs(), 3'b010);
        apply(8'hFE, 8'hF0, 1'b0, 1'b0, 1'b0); check("R6 -2>-16", outs(), 3'b100);
        apply(8'h00, 8'hFF, 1'b0, 1'b0, 1'b0); check("R6 0>-1", outs(), 3'b100);
        for (int i = 0; i < 20; i++) begin
            logic [7:0] a, b;
            a = 8'((i * 53 + 7) % 256);
            b = 8'((i * 29 + 130) % 256);
            apply(a, b, 1'b0, 1'b0, 1'b0);
            check("R6 sweep", outs(), ref_cmp({16'h0, a}, {16'h0, b}, 8, 1'b0, 1'b0, 1'b0));
        end
    endtask

    task automatic t_cascade_ignored();
        apply(8'd4, 8'd9, 1'b1, 1'b1, 1'b0); check("R7 lt despite gt_in", outs(), 3'b010);
        apply(8'd9, 8'd4, 1'b1, 1'b0, 1'b1); check("R7 gt despite lt_in", outs(), 3'b100);
        apply(8'd9, 8'd4, 1'b1, 1'b1, 1'b1); check("R7 both cascade high", outs(), 3'b100);
    endtask

    task automatic t_cascade_equal();
        apply(8'd77, 8'd77, 1'b1, 1'b0, 1'b0); check("R8 R9 eq none", outs(), 3'b001);
        apply(8'd77, 8'd77, 1'b1, 1'b1, 1'b0); check("R8 R9 eq gt_in", outs(), 3'b100);
        apply(8'd77, 8'd77, 1'b0, 1'b0, 1'b1); check("R8 R9 eq lt_in", outs(), 3'b010);
        apply(8'd77, 8'd77, 1'b1, 1'b1, 1'b1); check("R8 eq both in", outs(), 3'b110);
    endtask

    task automatic t_hold_p();
        apply(8'd10, 8'd20, 1'b1, 1'b0, 1'b0);
        p_load = 1'b0; p_in = 8'd30;
        repeat (3) @(negedge clk);
        check("R2 P held", outs(), 3'b010);
        p_load = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 P loaded", outs(), 3'b100);
    endtask

    task automatic t_hold_q();
        apply(8'd10, 8'd20, 1'b1, 1'b0, 1'b0);
        q_load = 1'b0; q_in = 8'd5;
        repeat (3) @(negedge clk);
        check("R3 Q held", outs(), 3'b010);
        q_load = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 Q loaded", outs(), 3'b100);
    endtask

    task automatic t_hold_res();
        apply(8'd1, 8'd2, 1'b1, 1'b0, 1'b0);
        res_load = 1'b0; p_in = 8'd3; gt_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 result held", outs(), 3'b010);
        res_load = 1'b1;
        @(negedge clk);
        check("R10 result one edge", outs(), 3'b100);
        gt_in = 1'b0;
    endtask

    task automatic t_clear();
        apply(8'd5, 8'd9, 1'b1, 1'b0, 1'b0);
        check("R4 before clear", outs(), 3'b010);
        q_clr_n = 1'b0; q_in = 8'd200; q_load = 1'b1;
        @(negedge clk);
        check("R4 async clear overrides load", outs(), 3'b100);
        p_in = 8'd0;
        repeat (2) @(negedge clk);
        check("R4 P vs zero", outs(), 3'b001);
        q_load = 1'b0; q_in = 8'd77; q_clr_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 Q stays zero", outs(), 3'b001);
        q_load = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 Q reloads", outs(), 3'b010);
    endtask

    task automatic t_chain();
        logic [23:0] a, b;
        logic [31:0] seed;
        seed = 32'h1234_5678;
        for (int i = 0; i < 48; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = seed[31:8];
            seed = seed * 32'd1664525 + 32'd1013904223;
            b = seed[31:8];
            if (i % 4 == 1) b = a;
            if (i % 4 == 2) b = {a[23:8], ~a[7:0]};
            if (i % 4 == 3) b = {a[23:16], b[15:0]};
            c_p = a; c_q = b; c_mode = i[3];
            repeat (5) @(negedge clk);
            check("R11 chain16", {c2_gt[2], c2_lt[2], c2_eq[2]},
                  ref_cmp(a, b, 16, c_mode, 1'b0, 1'b0));
            check("R11 chain24", {c3_gt[3], c3_lt[3], c3_eq[3]},
                  ref_cmp(a, b, 24, c_mode, 1'b0, 1'b0));
            check("R11 chain24 wired eq", {2'b00, &c3_eq}, {2'b00, c3_eq[3]});
        end
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        t_unsigned();
        t_signed();
        t_cascade_ignored();
        t_cascade_equal();
        t_hold_p();
        t_hold_q();
        t_hold_res();
        t_clear();
        t_chain();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule